// File: doc/BRIEF.md
# Tagged Block Zeroing Sequencer

This block carries out one "tag and clear" command at a time. It sets a 4-bit tag and zero data for every 16-byte granule of a naturally aligned memory block. The command supplies these fields:

- a 64-bit source value, whose low nibble is the tag;
- a base address, with a flag that marks the base as the stack pointer;
- a block-size exponent;
- the privilege level of the requester.

The block checks the command before it issues any write. The command is refused if it comes from the lowest privilege level. It is also refused if it uses a stack-pointer base that is not granule aligned, or if it gives an exponent outside the supported range. A refused command reports a one-cycle error with a code and writes nothing.

An accepted command rounds the address down to the block size. It then walks the block one granule at a time. For each granule it offers a tag write and a zero-data write on two independent valid/ready ports. The granule counts as done, and the address moves on, only when both writes have been accepted. A one-cycle done pulse follows the last granule.

Top module: `tag_zero_seq`

## Requirements
- R1: Every tag write carries bits [3:0] of `cmdSrc`; bits [63:4] have no effect on any output.
- R2: An accepted command with exponent BS makes exactly (4 << BS) / 16 tag writes and the same number of data writes.
- R3: The first write goes to `cmdBase` rounded down to a multiple of 4 << BS. Later writes rise by 16 per granule, and tag and data writes for a granule use the same address.
- R4: Every data write carries 128 zero bits.
- R5: A command with `cmdPriv` = 0 produces `errValid` with `errCode` = 1 in the cycle after acceptance, and makes no writes.
- R6: A command with `cmdUseSp` = 1 and `cmdBase[3:0]` not zero produces `errCode` = 2 and makes no writes. With `cmdUseSp` = 0 a base of any alignment is accepted.
- R7: A command with `cmdBsExp` below 2 or above 9 produces `errCode` = 3 and makes no writes.
- R8: When several checks fail, the code reported is that of the privilege check (1), then the alignment check (2), then the size check (3).
- R9: A write's valid, address and tag hold until it is accepted. Each port writes each granule once. The address advances only when both writes of a granule are accepted.
- R10: With both ports always ready, one granule completes per clock. `done` is high for exactly one cycle, the cycle after the last granule is accepted.
- R11: `cmdReady` is high only while idle. A `cmdValid` presented while busy is ignored and starts no later run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle, command taken this cycle |
| cmdSrc | input | 64 | Source value; low nibble is the tag |
| cmdBase | input | 64 | Base address |
| cmdUseSp | input | 1 | Base is the stack pointer (alignment checked) |
| cmdBsExp | input | 4 | Block-size exponent BS (bytes = 4 << BS) |
| cmdPriv | input | 2 | Requester privilege level, 0 is lowest |
| tagValid | output | 1 | Tag write offered |
| tagReady | input | 1 | Tag store accepts |
| tagAddr | output | 64 | Granule address for tag write |
| tagData | output | 4 | Tag value |
| dataValid | output | 1 | Data write offered |
| dataReady | input | 1 | Data store accepts |
| dataAddr | output | 64 | Granule address for data write |
| dataBytes | output | 128 | Granule data (all zero) |
| done | output | 1 | One-cycle completion pulse |
| errValid | output | 1 | One-cycle command refusal pulse |
| errCode | output | 2 | 1 privilege, 2 alignment, 3 size, 0 otherwise |

## Verification
Assertions check on every cycle that a pending write holds its valid and address under back-pressure. They also check that each granule address is aligned, that `done` never lasts two cycles, and that a refused command leads straight to an error with no write offered. The following can only be shown by the bench scenarios:

- the exact granule count for each exponent;
- the rounded-down start address;
- the error priority when several checks fail;
- one-granule-per-clock throughput;
- a busy-time command that leaves no trace.

// File: rtl/tzs_pkg.sv
package tzs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2,
    ST_FAIL = 2'd3
  } state_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_PRIV  = 2'd1,
    ERR_ALIGN = 2'd2,
    ERR_SIZE  = 2'd3
  } err_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture a new command
    logic step;  // one granule finished on both ports
  } strobe_t;

endpackage

// File: rtl/tzs_datapath.sv
module tzs_datapath
  import tzs_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int TAG_W      = 4,
  parameter int GRAN_BYTES = 16,
  parameter int BS_W       = 4,
  parameter int BS_MIN     = 2,
  parameter int BS_MAX     = 9,
  parameter int PRIV_W     = 2,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [TAG_W-1:0]  cmdTag,
  input  logic [ADDR_W-1:0] cmdBase,
  input  logic              cmdUseSp,
  input  logic [BS_W-1:0]   cmdBsExp,
  input  logic [PRIV_W-1:0] cmdPriv,
  output logic [ADDR_W-1:0] curAddr,
  output logic [TAG_W-1:0]  curTag,
  output logic              lastGran,
  output err_t              checkErr,
  output logic              zeroCount
);

  localparam int GRAN_LG = $clog2(GRAN_BYTES);

  logic [ADDR_W-1:0] blockBytes;
  logic [ADDR_W-1:0] alignedBase;
  logic [CNT_W-1:0]  granCount;
  logic [CNT_W-1:0]  remain;

  // command-side decode: size, rounding and gate checks
  always_comb begin
    blockBytes  = ADDR_W'(4) << cmdBsExp;
    alignedBase = cmdBase & ~(blockBytes - ADDR_W'(1));
    granCount   = CNT_W'(blockBytes >> GRAN_LG);
    zeroCount   = (granCount == '0);
    if (cmdPriv == '0)
      checkErr = ERR_PRIV;
    else if (cmdUseSp && (cmdBase[GRAN_LG-1:0] != '0))
      checkErr = ERR_ALIGN;
    else if ((cmdBsExp < BS_W'(BS_MIN)) || (cmdBsExp > BS_W'(BS_MAX)))
      checkErr = ERR_SIZE;
    else
      checkErr = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curTag  <= '0;
      remain  <= '0;
    end else if (strobe.load) begin
      curAddr <= alignedBase;
      curTag  <= cmdTag;
      remain  <= granCount;
    end else if (strobe.step) begin
      curAddr <= curAddr + ADDR_W'(GRAN_BYTES);
      remain  <= remain - CNT_W'(1);
    end
  end

  assign lastGran = (remain == CNT_W'(1));

  // every granule address after a step stays granule aligned
  assert_step_aligned_R3 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (curAddr[GRAN_LG-1:0] == '0));

endmodule

// File: rtl/tzs_ctrl.sv
module tzs_ctrl
  import tzs_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  err_t    checkErr,
  input  logic    zeroCount,
  input  logic    lastGran,
  input  logic    tagReady,
  input  logic    dataReady,
  output strobe_t strobe,
  output logic    cmdReady,
  output logic    tagValid,
  output logic    dataValid,
  output logic    done,
  output logic    errValid,
  output err_t    errCode
);

  state_t state;
  logic   tagSent, dataSent;
  err_t   errReg;
  logic   tagFire, dataFire, granDone, accept;

  always_comb begin
    cmdReady    = (state == ST_IDLE);
    accept      = cmdReady && cmdValid;
    tagValid    = (state == ST_RUN) && !tagSent;
    dataValid   = (state == ST_RUN) && !dataSent;
    tagFire     = tagValid && tagReady;
    dataFire    = dataValid && dataReady;
    granDone    = (state == ST_RUN) && (tagSent || tagFire) && (dataSent || dataFire);
    strobe.load = accept;
    strobe.step = granDone;
    done        = (state == ST_FIN);
    errValid    = (state == ST_FAIL);
    errCode     = errValid ? errReg : ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tagSent  <= 1'b0;
      dataSent <= 1'b0;
      errReg   <= ERR_NONE;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          if (checkErr != ERR_NONE) begin
            state  <= ST_FAIL;
            errReg <= checkErr;
          end else if (zeroCount) begin
            state <= ST_FIN;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: if (granDone && lastGran) state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
      if (granDone) begin
        tagSent  <= 1'b0;
        dataSent <= 1'b0;
      end else begin
        if (tagFire)  tagSent  <= 1'b1;
        if (dataFire) dataSent <= 1'b1;
      end
    end
  end

  assert_tag_hold_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (tagValid && !tagReady) |=> tagValid);
  assert_data_hold_R9 : assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataReady) |=> dataValid);
  assert_refuse_quiet_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (accept && (checkErr != ERR_NONE)) |=> (errValid && !tagValid && !dataValid));
  assert_done_pulse_R10 : assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/tag_zero_seq.sv
module tag_zero_seq
  import tzs_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int SRC_W      = 64,
  parameter int TAG_W      = 4,
  parameter int GRAN_BYTES = 16,
  parameter int BS_W       = 4,
  parameter int BS_MIN     = 2,
  parameter int BS_MAX     = 9,
  parameter int PRIV_W     = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  output logic                    cmdReady,
  input  logic [SRC_W-1:0]        cmdSrc,
  input  logic [ADDR_W-1:0]       cmdBase,
  input  logic                    cmdUseSp,
  input  logic [BS_W-1:0]         cmdBsExp,
  input  logic [PRIV_W-1:0]       cmdPriv,
  output logic                    tagValid,
  input  logic                    tagReady,
  output logic [ADDR_W-1:0]       tagAddr,
  output logic [TAG_W-1:0]        tagData,
  output logic                    dataValid,
  input  logic                    dataReady,
  output logic [ADDR_W-1:0]       dataAddr,
  output logic [8*GRAN_BYTES-1:0] dataBytes,
  output logic                    done,
  output logic                    errValid,
  output logic [1:0]              errCode
);

  localparam int GRAN_LG = $clog2(GRAN_BYTES);
  localparam int MAX_CNT = (4 << BS_MAX) >> GRAN_LG;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  strobe_t           strobe;
  err_t              checkErr;
  err_t              errCodeInt;
  logic              zeroCount, lastGran;
  logic [ADDR_W-1:0] curAddr;

  tzs_datapath #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .GRAN_BYTES(GRAN_BYTES), .BS_W(BS_W),
    .BS_MIN(BS_MIN), .BS_MAX(BS_MAX), .PRIV_W(PRIV_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cmdTag(cmdSrc[TAG_W-1:0]), .cmdBase(cmdBase), .cmdUseSp(cmdUseSp),
    .cmdBsExp(cmdBsExp), .cmdPriv(cmdPriv),
    .curAddr(curAddr), .curTag(tagData), .lastGran(lastGran),
    .checkErr(checkErr), .zeroCount(zeroCount)
  );

  tzs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .checkErr(checkErr),
    .zeroCount(zeroCount), .lastGran(lastGran),
    .tagReady(tagReady), .dataReady(dataReady), .strobe(strobe),
    .cmdReady(cmdReady), .tagValid(tagValid), .dataValid(dataValid),
    .done(done), .errValid(errValid), .errCode(errCodeInt)
  );

  assign tagAddr   = curAddr;
  assign dataAddr  = curAddr;
  assign dataBytes = '0;
  assign errCode   = errCodeInt;

endmodule

// File: tb/tag_zero_seq_test.sv
module tag_zero_seq_test;

  typedef struct packed {
    logic [63:0] src;
    logic [63:0] base;
    logic        useSp;
    logic [3:0]  bs;
    logic [1:0]  priv;
    logic [1:0]  err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{64'hFFFF_FFFF_FFFF_FFF5, 64'h1000_0037, 1'b0, 4'd2,  2'd1, 2'd0},
    '{64'h0000_0000_0000_000A, 64'h2000_01F8, 1'b0, 4'd4,  2'd2, 2'd0},
    '{64'h1234_5678_9ABC_DEF3, 64'h3000_0ABC, 1'b0, 4'd9,  2'd3, 2'd0},
    '{64'h0000_0000_0000_00FC, 64'h4000_0100, 1'b1, 4'd6,  2'd1, 2'd0},
    '{64'h0000_0000_0000_0001, 64'h5000_0000, 1'b0, 4'd4,  2'd0, 2'd1},
    '{64'h0000_0000_0000_0001, 64'h6000_0008, 1'b1, 4'd4,  2'd1, 2'd2},
    '{64'h0000_0000_0000_0001, 64'h7000_0000, 1'b0, 4'd10, 2'd1, 2'd3},
    '{64'h0000_0000_0000_0001, 64'h7000_0000, 1'b0, 4'd1,  2'd1, 2'd3},
    '{64'h0000_0000_0000_0001, 64'h8000_0004, 1'b1, 4'd12, 2'd0, 2'd1},
    '{64'h0000_0000_0000_0001, 64'h8000_0004, 1'b1, 4'd12, 2'd1, 2'd2},
    '{64'hABCD_0000_0000_0006, 64'h9000_0077, 1'b0, 4'd5,  2'd1, 2'd0}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic         cmdReady;
  logic [63:0]  cmdSrc = '0;
  logic [63:0]  cmdBase = '0;
  logic         cmdUseSp = 1'b0;
  logic [3:0]   cmdBsExp = '0;
  logic [1:0]   cmdPriv = '0;
  logic         tagValid, dataValid;
  logic         tagReady = 1'b0, dataReady = 1'b0;
  logic [63:0]  tagAddr, dataAddr;
  logic [3:0]   tagData;
  logic [127:0] dataBytes;
  logic         done, errValid;
  logic [1:0]   errCode;

  int  total = 0;
  int  bad = 0;
  bit  ended = 0;
  logic [1:0] lastErr;

  always #10 clk = ~clk;

  tag_zero_seq uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdSrc(cmdSrc), .cmdBase(cmdBase), .cmdUseSp(cmdUseSp),
    .cmdBsExp(cmdBsExp), .cmdPriv(cmdPriv),
    .tagValid(tagValid), .tagReady(tagReady), .tagAddr(tagAddr), .tagData(tagData),
    .dataValid(dataValid), .dataReady(dataReady), .dataAddr(dataAddr),
    .dataBytes(dataBytes), .done(done), .errValid(errValid), .errCode(errCode)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic string errReq(input logic [1:0] c);
    case (c)
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // mode 0: both ports always ready; mode 1: uneven back-pressure
  task automatic runCmd(input vec_t v, input int mode, input bit intrude);
    logic [63:0] blk, expBase;
    int expCount, tagN, dataN, doneAt;
    bit errSeen, finished;
    blk      = 64'd4 << v.bs;
    expBase  = v.base & ~(blk - 64'd1);
    expCount = int'(blk >> 4);
    tagN = 0; dataN = 0; doneAt = -1; errSeen = 0; finished = 0;
    lastErr = 2'd0;
    @(negedge clk);
    cmdSrc = v.src; cmdBase = v.base; cmdUseSp = v.useSp;
    cmdBsExp = v.bs; cmdPriv = v.priv; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    for (int i = 0; i < 3000 && !finished; i++) begin
      if (i > 0) @(negedge clk);
      if (intrude && i == 1) begin
        check(cmdReady == 1'b0, "R11", "cmdReady while busy", 64'(cmdReady), 64'd0);
        cmdValid = 1'b1; cmdBase = 64'hDEAD_0000; cmdBsExp = 4'd2; cmdSrc = 64'h0;
        cmdPriv = 2'd1; cmdUseSp = 1'b0;
      end
      if (intrude && i == 3) cmdValid = 1'b0;
      if (mode == 0) begin
        tagReady = 1'b1; dataReady = 1'b1;
      end else begin
        tagReady  = (i % 3) != 1;
        dataReady = (i % 4) >= 2;
      end
      if (tagValid && tagReady) begin
        check(tagAddr == expBase + 64'(16 * tagN), "R3", "tag address",
              tagAddr, expBase + 64'(16 * tagN));
        check(tagData == v.src[3:0], "R1", "tag value", 64'(tagData), 64'(v.src[3:0]));
        tagN++;
      end
      if (dataValid && dataReady) begin
        check(dataAddr == expBase + 64'(16 * dataN), "R3", "data address",
              dataAddr, expBase + 64'(16 * dataN));
        check(dataBytes == '0, "R4", "data zero", dataBytes[63:0] | dataBytes[127:64], 64'd0);
        dataN++;
      end
      if (errValid) begin
        errSeen = 1; finished = 1; lastErr = errCode;
        check(errCode == v.err, (v.err == 0) ? "R2" : errReq(v.err), "error code",
              64'(errCode), 64'(v.err));
      end
      if (done) begin
        doneAt = i; finished = 1;
      end
    end
    cmdValid = 1'b0;
    if (v.err != 0) begin
      check(errSeen && doneAt < 0, errReq(v.err), "refused without done", 64'(errSeen), 64'd1);
      check(tagN == 0 && dataN == 0, errReq(v.err), "no writes on refusal",
            64'(tagN + dataN), 64'd0);
    end else begin
      check(doneAt >= 0, "R10", "done seen", 64'(doneAt), 64'(expCount));
      check(tagN == expCount, "R2", "tag write count", 64'(tagN), 64'(expCount));
      check(dataN == expCount, "R2", "data write count", 64'(dataN), 64'(expCount));
      if (mode == 0)
        check(doneAt == expCount, "R10", "one granule per clock", 64'(doneAt), 64'(expCount));
    end
    // following cycles: pulse gone, idle, nothing written
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      check(!done && !errValid && !tagValid && !dataValid,
            intrude ? "R11" : "R10", "quiet after end",
            {60'd0, done, errValid, tagValid, dataValid}, 64'd0);
    end
    check(cmdReady == 1'b1, "R11", "idle after end", 64'(cmdReady), 64'd1);
    tagReady = 1'b0; dataReady = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmdReady == 1'b1 && !tagValid && !dataValid && !done && !errValid,
          "R11", "reset state",
          {59'd0, cmdReady, tagValid, dataValid, done, errValid}, 64'h10);
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      runCmd(VECS[k], 0, 1'b0);
      if (k == 8) check(lastErr == 2'd1, "R8", "priv beats align and size", 64'(lastErr), 64'd1);
      if (k == 9) check(lastErr == 2'd2, "R8", "align beats size", 64'(lastErr), 64'd2);
    end

    // R9: back-pressure on both ports, independent patterns
    runCmd(VECS[1], 1, 1'b0);
    runCmd(VECS[3], 1, 1'b0);
    // R11: command offered while busy is dropped
    runCmd(VECS[1], 1, 1'b1);
    // R1: same command, different upper source bits, same writes
    runCmd('{64'h5A5A_5A5A_5A5A_5A55, 64'h1000_0037, 1'b0, 4'd2, 2'd1, 2'd0}, 0, 1'b0);

    finishRun();
  end

endmodule